// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects three reset requests: an active-low external reset pin, a one-cycle software reset strobe and a one-cycle watchdog overflow pulse. Any of them starts a reset sequence of fixed length, and the block holds the internal core reset for that time. It also drives an external reset output and an enable for the bus and I/O pin drivers. It raises an abort request towards the bus controller for an external bus cycle, and it sends one-cycle abort strobes to the serial bus, the line transceiver and the hold logic.

The sources are not treated alike. A pin reset always drives the external reset output. A watchdog reset drives it only when an enable input is set, and a software reset never drives it. Hardware and software resets abort an external bus cycle. A watchdog reset does not abort it and waits for it to end. For every source, an internal access that is already in progress finishes before the pin drivers turn off.

The reset is released only when two things are true: the sequence is complete and the synchronized pin is high. On release the block latches a configuration word from its port input. It also gives a one-cycle start strobe, which tells the core to put its bus strobes into the idle state and fetch from address zero. A cause code shows which source caused the most recent reset, and it keeps this value after release.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `core_rst`=1, `rst_out`=1, `pin_oe`=0 and `cause`=2'b01. A full sequence then runs as for a pin reset, and `core_rst` stays high for exactly SEQ_LEN clocks after the last clock edge with `rst` high.
- R2: The pin input passes through a two-stage synchronizer, and a high-to-low change of the synchronized pin is a hardware request. `core_rst` rises at the third rising edge after `rst_pin_n` goes low.
- R3: If no new request arrives, the pin stays high and the drivers have already turned off, `core_rst` stays high for exactly SEQ_LEN clocks after the request is accepted.
- R4: `core_rst` never falls while the synchronized pin is low. When the pin rises after the sequence is complete, `core_rst` falls at the third rising edge after the rise.
- R5: `rst_out` rises together with `core_rst` for a hardware request, and for a watchdog request when `wdt_rst_out_en`=1. It stays low for a software-only request or for a watchdog request with the enable at 0. It falls together with `core_rst`.
- R6: A hardware or software request raises `ext_abort` on the next clock. A watchdog-only request never raises it. `ext_abort` clears when the drivers turn off.
- R7: `pin_oe` stays 1 while `int_access_busy` is high. It also stays 1 while `ext_cycle_busy` is high if no abort is in progress. It falls at the first edge where these conditions are cleared.
- R8: Every accepted request, including one that arrives during a reset, gives a one-cycle pulse on `hold_cancel`, `ser_abort` and `xcvr_off` on the next clock.
- R9: At release, `cfg_word` takes the value of `cfg_port` at that edge, `rel_stb` is high for one cycle and `pin_oe` returns to 1.
- R10: A request accepted during an active reset restarts the SEQ_LEN count.
- R11: `cause` uses these codes: 2'b01 for hardware, 2'b10 for software and 2'b11 for watchdog. When requests arrive together, hardware wins over watchdog, and watchdog wins over software. The value is kept after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_stb | input | 1 | Software reset strobe, one cycle |
| wdt_ovf | input | 1 | Watchdog overflow pulse, one cycle |
| wdt_rst_out_en | input | 1 | Lets a watchdog reset drive `rst_out` |
| int_access_busy | input | 1 | Internal access in progress |
| ext_cycle_busy | input | 1 | External bus cycle in progress |
| cfg_port | input | CFG_W | Configuration port sampled at release |
| core_rst | output | 1 | Internal reset |
| rst_out | output | 1 | External reset output |
| pin_oe | output | 1 | Bus and I/O pin driver enable (0 = high impedance) |
| ext_abort | output | 1 | Abort request to the bus controller |
| hold_cancel | output | 1 | One-cycle pulse: cancel pending hold states |
| ser_abort | output | 1 | One-cycle pulse: abort serial bus access, return it to idle |
| xcvr_off | output | 1 | One-cycle pulse: deactivate the line transceiver |
| rel_stb | output | 1 | One-cycle release strobe: idle strobes, fetch from zero |
| cfg_word | output | CFG_W | Configuration word latched at release |
| cause | output | 2 | Source of the most recent reset |

## Verification
The assertions assume that `sw_rst_stb` and `wdt_ovf` are single-cycle pulses synchronous to `clk`. They also assume that the two busy inputs fall within a bounded time, so that the drain step cannot hold reset forever. The bench drives every input on the falling clock edge. It keeps each request pulse one cycle wide, and it always releases each busy input after a short hold. Requests that must arrive together are timed so that they reach the sequencer in the same cycle as the synchronized pin edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_HW   = 2'b01,
    CAUSE_SW   = 2'b10,
    CAUSE_WDT  = 2'b11
  } cause_e;
endpackage

// File: rtl/rstseq_sync.sv
// Pin synchronizer with falling-edge detect (R2).
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic pin_hi_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-1:0], pin_n_i};
  end

  assign pin_hi_o = sh_q[STAGES-1];
  assign fall_o   = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/rstseq_arb.sv
// Request merge and source priority (R5, R6, R11).
module rstseq_arb
  import rstseq_pkg::*;
(
  input  logic   hw_i,
  input  logic   sw_i,
  input  logic   wdt_i,
  input  logic   wdt_out_en_i,
  output logic   ev_o,
  output logic   drive_out_o,
  output logic   abort_o,
  output cause_e cause_o
);
  always_comb begin
    ev_o        = hw_i | sw_i | wdt_i;
    drive_out_o = hw_i | (wdt_i & wdt_out_en_i);
    abort_o     = hw_i | sw_i;
    if (hw_i)       cause_o = CAUSE_HW;
    else if (wdt_i) cause_o = CAUSE_WDT;
    else            cause_o = CAUSE_SW;
  end
endmodule

// File: rtl/rstseq_timer.sv
// Sequence length counter, restarted by clr (R3, R10).
module rstseq_timer #(
  parameter int SEQ_LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CNT_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)               cnt_q <= '0;
    else if (en && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LAST);
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rstseq_pkg::*;
#(
  parameter int SEQ_LEN     = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_pin_n,
  input  logic             sw_rst_stb,
  input  logic             wdt_ovf,
  input  logic             wdt_rst_out_en,
  input  logic             int_access_busy,
  input  logic             ext_cycle_busy,
  input  logic [CFG_W-1:0] cfg_port,
  output logic             core_rst,
  output logic             rst_out,
  output logic             pin_oe,
  output logic             ext_abort,
  output logic             hold_cancel,
  output logic             ser_abort,
  output logic             xcvr_off,
  output logic             rel_stb,
  output logic [CFG_W-1:0] cfg_word,
  output logic [1:0]       cause
);
  logic   pin_hi, hw_ev, ev_any, drive_out, abort_req, seq_done;
  logic   drained, drain_ok, rel_ok;
  cause_e cause_nxt;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n_i(rst_pin_n),
    .pin_hi_o(pin_hi), .fall_o(hw_ev)
  );

  rstseq_arb u_arb (
    .hw_i(hw_ev), .sw_i(sw_rst_stb), .wdt_i(wdt_ovf),
    .wdt_out_en_i(wdt_rst_out_en), .ev_o(ev_any),
    .drive_out_o(drive_out), .abort_o(abort_req), .cause_o(cause_nxt)
  );

  rstseq_timer #(.SEQ_LEN(SEQ_LEN)) u_timer (
    .clk(clk), .rst(rst), .clr(ev_any), .en(core_rst), .done(seq_done)
  );

  // Drain: internal access must end; an unaborted external cycle too (R7).
  assign drain_ok = core_rst & ~drained & ~int_access_busy
                  & (ext_abort | ~ext_cycle_busy);
  // Release: drained, sequence complete and pin high (R3, R4).
  assign rel_ok   = core_rst & drained & seq_done & pin_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst    <= 1'b1;
      rst_out     <= 1'b1;
      pin_oe      <= 1'b0;
      ext_abort   <= 1'b0;
      drained     <= 1'b1;
      hold_cancel <= 1'b0;
      ser_abort   <= 1'b0;
      xcvr_off    <= 1'b0;
      rel_stb     <= 1'b0;
      cfg_word    <= '0;
      cause       <= CAUSE_HW;
    end else begin
      hold_cancel <= ev_any;
      ser_abort   <= ev_any;
      xcvr_off    <= ev_any;
      rel_stb     <= 1'b0;
      if (ev_any) begin
        core_rst  <= 1'b1;
        cause     <= cause_nxt;
        rst_out   <= (core_rst & rst_out) | drive_out;
        ext_abort <= abort_req & ~(core_rst & drained);
        drained   <= core_rst & drained;
      end else if (drain_ok) begin
        drained   <= 1'b1;
        pin_oe    <= 1'b0;
        ext_abort <= 1'b0;
      end else if (rel_ok) begin
        core_rst  <= 1'b0;
        rst_out   <= 1'b0;
        pin_oe    <= 1'b1;
        rel_stb   <= 1'b1;
        cfg_word  <= cfg_port;
      end
    end
  end
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int SEQ_LEN = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       core_rst,
  input logic       rst_out,
  input logic       pin_oe,
  input logic       ext_abort,
  input logic       hold_cancel,
  input logic       ser_abort,
  input logic       xcvr_off,
  input logic       rel_stb,
  input logic [1:0] cause,
  input logic       int_access_busy,
  input logic       wdt_ovf,
  input logic       sw_rst_stb,
  input logic       hw_ev,
  input logic       ev_any,
  input logic       pin_hi
);
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || ev_any)                 run_q <= '0;
    else if (core_rst && run_q != '1)  run_q <= run_q + 1;
  end

  p_min_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> run_q >= 32'(SEQ_LEN));

  p_pin_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (core_rst && !pin_hi) |=> core_rst);

  p_out_in_rst_r5: assert property (@(posedge clk) disable iff (rst)
    rst_out |-> core_rst);

  p_sw_no_out_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_any && !hw_ev && !wdt_ovf && !core_rst) |=> !rst_out);

  p_wdt_no_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_any && !hw_ev && !sw_rst_stb && !core_rst) |=> !ext_abort);

  p_drain_wait_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_oe) |-> (core_rst && $past(!int_access_busy)));

  p_strobes_r8: assert property (@(posedge clk) disable iff (rst)
    ev_any |=> (hold_cancel && ser_abort && xcvr_off));

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (rel_stb && pin_oe));

  p_hw_cause_r11: assert property (@(posedge clk) disable iff (rst)
    hw_ev |=> cause == 2'b01);
endmodule

bind rst_sequencer rstseq_chk #(.SEQ_LEN(SEQ_LEN)) u_chk (
  .clk(clk), .rst(rst), .core_rst(core_rst), .rst_out(rst_out),
  .pin_oe(pin_oe), .ext_abort(ext_abort), .hold_cancel(hold_cancel),
  .ser_abort(ser_abort), .xcvr_off(xcvr_off), .rel_stb(rel_stb),
  .cause(cause), .int_access_busy(int_access_busy), .wdt_ovf(wdt_ovf),
  .sw_rst_stb(sw_rst_stb), .hw_ev(hw_ev), .ev_any(ev_any), .pin_hi(pin_hi)
);

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;
  localparam int SEQ = 1024;
  localparam int CW  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, pin, sw, wdt, en, ib, eb;
  logic [CW-1:0] cfg;
  logic core_rst, rst_out, pin_oe, ext_abort, hold_cancel, ser_abort, xcvr_off, rel_stb;
  logic [CW-1:0] cfg_word;
  logic [1:0] cause;

  rst_sequencer #(.SEQ_LEN(SEQ), .CFG_W(CW)) i_rst_sequencer (
    .clk(clk), .rst(rst), .rst_pin_n(pin), .sw_rst_stb(sw), .wdt_ovf(wdt),
    .wdt_rst_out_en(en), .int_access_busy(ib), .ext_cycle_busy(eb),
    .cfg_port(cfg), .core_rst(core_rst), .rst_out(rst_out), .pin_oe(pin_oe),
    .ext_abort(ext_abort), .hold_cancel(hold_cancel), .ser_abort(ser_abort),
    .xcvr_off(xcvr_off), .rel_stb(rel_stb), .cfg_word(cfg_word), .cause(cause)
  );

  int checks = 0;
  int errors = 0;
  bit go = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: pin delay line, countdown of remaining cycles.
  bit p1, p2, p3;
  bit m_rst, m_out, m_oe, m_abt, m_dr, m_pulse, m_rel;
  int m_left;
  logic [1:0] m_cause;
  logic [CW-1:0] m_cfg;

  always @(posedge clk) begin
    bit hw, ev, hi;
    if (rst) begin
      p1 = 1; p2 = 1; p3 = 1;
      m_rst = 1; m_out = 1; m_oe = 0; m_abt = 0; m_dr = 1;
      m_pulse = 0; m_rel = 0; m_left = SEQ - 1; m_cause = 2'b01; m_cfg = '0;
    end else begin
      hw = p3 && !p2;
      hi = p2;
      p3 = p2; p2 = p1; p1 = pin;
      ev = hw || sw || wdt;
      m_pulse = ev;
      m_rel = 0;
      if (ev) begin
        m_cause = hw ? 2'b01 : (wdt ? 2'b11 : 2'b10);
        m_out   = (m_rst && m_out) || hw || (wdt && en);
        m_abt   = (hw || sw) && !(m_rst && m_dr);
        m_dr    = m_rst && m_dr;
        m_rst   = 1;
        m_left  = SEQ - 1;
      end else if (m_rst) begin
        if (!m_dr && !ib && (m_abt || !eb)) begin
          m_dr = 1; m_oe = 0; m_abt = 0;
        end else if (m_dr && m_left == 0 && hi) begin
          m_rst = 0; m_out = 0; m_oe = 1; m_rel = 1; m_cfg = cfg;
        end
        if (m_left > 0) m_left--;
      end
    end
  end

  always @(negedge clk) begin
    if (go && !finished) begin
      chk("R3 core_rst", 32'(core_rst), 32'(m_rst));
      chk("R5 rst_out", 32'(rst_out), 32'(m_out));
      chk("R7 pin_oe", 32'(pin_oe), 32'(m_oe));
      chk("R6 ext_abort", 32'(ext_abort), 32'(m_abt));
      chk("R8 strobes", 32'({hold_cancel, ser_abort, xcvr_off}), 32'({3{m_pulse}}));
      chk("R9 rel_stb", 32'(rel_stb), 32'(m_rel));
      chk("R9 cfg_word", 32'(cfg_word), 32'(m_cfg));
      chk("R11 cause", 32'(cause), 32'(m_cause));
    end
  end

  task automatic run_len(output int n);
    n = 0;
    while (core_rst) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw = 1;
    @(negedge clk) sw = 0;
  endtask

  task automatic pulse_wdt();
    @(negedge clk) wdt = 1;
    @(negedge clk) wdt = 0;
  endtask

  initial begin
    int n;
    rst = 1; pin = 1; sw = 0; wdt = 0; en = 0; ib = 0; eb = 0; cfg = 16'h1234;
    @(negedge clk);
    go = 1;
    chk("R1 core_rst", 32'(core_rst), 32'd1);
    chk("R1 rst_out", 32'(rst_out), 32'd1);
    chk("R1 pin_oe", 32'(pin_oe), 32'd0);
    chk("R1 cause", 32'(cause), 32'd1);
    repeat (2) @(negedge clk);
    rst = 0;
    run_len(n);
    chk("R1 length", 32'(n), 32'(SEQ));
    chk("R9 rel_stb", 32'(rel_stb), 32'd1);
    chk("R9 cfg", 32'(cfg_word), 32'h1234);
    cfg = 16'hBEEF;
    repeat (5) @(negedge clk);

    // Software reset with an external cycle busy: aborted, drivers off next clock.
    eb = 1;
    pulse_sw();
    chk("R8 hold_cancel", 32'(hold_cancel), 32'd1);
    chk("R5 sw no rst_out", 32'(rst_out), 32'd0);
    chk("R6 sw abort", 32'(ext_abort), 32'd1);
    chk("R11 sw cause", 32'(cause), 32'd2);
    @(negedge clk);
    chk("R7 abort ignores busy", 32'(pin_oe), 32'd0);
    eb = 0;
    run_len(n);
    chk("R3 sw length", 32'(n), 32'(SEQ - 1));
    chk("R9 cfg", 32'(cfg_word), 32'hBEEF);
    repeat (5) @(negedge clk);

    // Pin reset held long.
    @(negedge clk) pin = 0;
    n = 0;
    while (!core_rst) begin n++; @(negedge clk); end
    chk("R2 latency", 32'(n), 32'd3);
    chk("R5 hw rst_out", 32'(rst_out), 32'd1);
    chk("R11 hw cause", 32'(cause), 32'd1);
    repeat (2000) @(negedge clk);
    chk("R4 still held", 32'(core_rst), 32'd1);
    pin = 1;
    run_len(n);
    chk("R4 release delay", 32'(n), 32'd3);
    repeat (5) @(negedge clk);

    // Watchdog, output disabled, both busy: waits for internal then external.
    en = 0; ib = 1; eb = 1;
    pulse_wdt();
    chk("R6 wdt no abort", 32'(ext_abort), 32'd0);
    chk("R5 wdt disabled", 32'(rst_out), 32'd0);
    chk("R11 wdt cause", 32'(cause), 32'd3);
    repeat (10) @(negedge clk);
    ib = 0;
    repeat (10) @(negedge clk);
    chk("R7 waits ext cycle", 32'(pin_oe), 32'd1);
    eb = 0;
    @(negedge clk);
    chk("R7 drivers off", 32'(pin_oe), 32'd0);
    run_len(n);
    repeat (5) @(negedge clk);

    // Watchdog with output enabled.
    en = 1;
    pulse_wdt();
    chk("R5 wdt enabled", 32'(rst_out), 32'd1);
    run_len(n);
    chk("R3 wdt length", 32'(n), 32'(SEQ));
    repeat (5) @(negedge clk);

    // Restart during reset.
    pulse_sw();
    repeat (500) @(negedge clk);
    pulse_sw();
    chk("R8 restart strobe", 32'(xcvr_off), 32'd1);
    run_len(n);
    chk("R10 restart length", 32'(n), 32'(SEQ));
    repeat (5) @(negedge clk);

    // Simultaneous requests.
    @(negedge clk) begin sw = 1; wdt = 1; end
    @(negedge clk) begin sw = 0; wdt = 0; end
    chk("R11 wdt over sw", 32'(cause), 32'd3);
    run_len(n);
    repeat (5) @(negedge clk);
    @(negedge clk) pin = 0;
    @(negedge clk);
    @(negedge clk) wdt = 1;
    @(negedge clk) wdt = 0;
    chk("R11 hw over wdt", 32'(cause), 32'd1);
    pin = 1;
    run_len(n);
    chk("R11 kept after release", 32'(cause), 32'd1);
    repeat (5) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule